// File: doc/BRIEF.md
# Throttled Clear-on-Read Interrupt Collector

This block gathers single-cycle event pulses from a set of sources, qualifies each one with its own enable bit, and records it in a status word that empties when it is read. An active-low interrupt line tells the host that the word holds something worth reading. Sources fall into two classes. Urgent causes pull the line low straight away. Routine causes are recorded straight away, but in Normal mode they may pull the line low no more than once in each watchdog period, so that a fault that toggles rapidly cannot flood the host.

A read returns the status word and empties it in the same cycle. A pulse that lands in that cycle is kept and is not lost. After every read the line is held high for a fixed number of cycles, so the host always sees a fresh falling edge when more work is waiting. A sequencer with three states drives the line: IDLE (line high, nothing to report), ASSERT (line low until a read) and HOLD (line high while the release counter runs). Its transitions are IDLE→ASSERT when a permitted cause is pending, IDLE→HOLD or ASSERT→HOLD on a read, HOLD→HOLD while counting or on a repeat read, HOLD→ASSERT when the count expires with a permitted cause pending, and HOLD→IDLE when it expires with none.

Top module: `irq_throttle_ctrl`

## Requirements
- R1: After reset the status word reads 0 and `irq_n_o` is high.
- R2: A pulse on `evt_i[b]` with `ena_i[b]` high sets status bit b on the next clock edge. With `ena_i[b]` low the bit stays clear and the line stays high. Bit positions: 11 watchdog timeout, 10 temperature change, 8 serial clock-count fault, 7 supply fault, 6 regulator fault, 4 bus fault change, 3 wake pin, 2 watchdog restart, 0 bus wake.
- R3: Bits 9, 5 and 1 always read 0, whatever is driven on their inputs.
- R4: `rd_data_o` shows the status word at all times. A cycle with `rd_i` high returns that value and empties the word at the next edge.
- R5: A qualified pulse in the same cycle as `rd_i` is present in the status word after that edge.
- R6: Urgent bits (11, 8, 7, 2) pull `irq_n_o` low one cycle after they appear in the status word, in any mode, whenever the release counter is idle.
- R7: Routine bits (10, 6, 4, 3, 0) act like urgent bits while `normal_i` is low.
- R8: While `normal_i` is high, once a routine cause has pulled the line low, further routine causes are recorded but do not pull it low again before the next `wd_tick_i`.
- R9: After a read `irq_n_o` is high for exactly REL_CYC cycles (default 4). It then goes low at once if a permitted cause is still pending.
- R10: Once low, `irq_n_o` stays low until a read.
- R11: A pulse on `wd_tick_i` re-arms routine signalling, so a pending routine cause pulls the line low one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 12 | Event pulses, one per status bit |
| ena_i | input | 12 | Enable bit for each source |
| rd_i | input | 1 | Read strobe; empties the status word |
| rd_data_o | output | 12 | Current status word |
| wd_tick_i | input | 1 | One pulse per watchdog period |
| normal_i | input | 1 | High while in Normal mode |
| irq_n_o | output | 1 | Interrupt line, active low |

## Verification
The assertions assume that `evt_i`, `rd_i` and `wd_tick_i` are synchronous to `clk` and are single-cycle pulses, and that `ena_i` and `normal_i` change only between test phases. The bench drives every input one time unit after a rising edge. It raises each strobe for exactly one cycle and changes the mode and the enables only while the line is high and nothing routine is pending. Under these conditions every assertion holds, including the one that ties the status word after a read to the pulses qualified in the read cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int STAT_W = 12;
    // bits that exist in the status word (9, 5, 1 are held at zero)
    localparam logic [STAT_W-1:0] VALID_MASK  = 12'b1101_1101_1101;
    // causes that signal at once in every mode
    localparam logic [STAT_W-1:0] URGENT_MASK = 12'b1001_1000_0100;
    // causes subject to the once-per-period limit in Normal mode
    localparam logic [STAT_W-1:0] ROUTINE_MASK = 12'b0100_0101_1001;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ASSERT = 2'd1,
        ST_HOLD   = 2'd2
    } seq_state_e;
endpackage

// File: rtl/irq_stat_latch.sv
module irq_stat_latch
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] evt_i,
    input  logic [STAT_W-1:0] ena_i,
    input  logic              rd_i,
    output logic [STAT_W-1:0] stat_o
);
    // one sticky cell per implemented bit; reserved bits stay at zero
    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
        if (VALID_MASK[b]) begin : g_cell
            logic hit;
            assign hit = evt_i[b] & ena_i[b];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    stat_o[b] <= 1'b0;
                else if (rd_i)
                    stat_o[b] <= hit;           // clear, but keep a same-cycle pulse
                else
                    stat_o[b] <= stat_o[b] | hit;
            end
        end else begin : g_rsvd
            assign stat_o[b] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_rate_gate.sv
module irq_rate_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic wd_tick_i,
    input  logic take_i,      // a routine cause launched the line in Normal mode
    output logic used_o       // routine signalling spent for this period
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            used_o <= 1'b0;
        else if (take_i)
            used_o <= 1'b1;
        else if (wd_tick_i)
            used_o <= 1'b0;
    end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_pkg::*;
#(
    parameter int REL_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_i,
    input  logic rd_i,
    output logic irq_n_o,
    output logic launch_o,
    output logic open_o
);
    localparam int CW = $clog2(REL_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(REL_CYC - 1);

    seq_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          expired;

    assign expired = (state_q == ST_HOLD) && (cnt_q == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_i) begin
                    state_d = ST_HOLD;
                    cnt_d   = LOAD;
                end else if (want_i) begin
                    state_d = ST_ASSERT;
                end
            end
            ST_ASSERT: begin
                if (rd_i) begin
                    state_d = ST_HOLD;
                    cnt_d   = LOAD;
                end
            end
            ST_HOLD: begin
                if (rd_i) begin
                    cnt_d = LOAD;
                end else if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end else if (want_i) begin
                    state_d = ST_ASSERT;
                end else begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        irq_n_o  = (state_q != ST_ASSERT);
        open_o   = (state_q != ST_HOLD) || expired;
        launch_o = !rd_i && want_i &&
                   ((state_q == ST_IDLE) || expired);
    end
endmodule

// File: rtl/irq_throttle_ctrl.sv
module irq_throttle_ctrl
    import irq_pkg::*;
#(
    parameter int REL_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] evt_i,
    input  logic [STAT_W-1:0] ena_i,
    input  logic              rd_i,
    output logic [STAT_W-1:0] rd_data_o,
    input  logic              wd_tick_i,
    input  logic              normal_i,
    output logic              irq_n_o
);
    logic [STAT_W-1:0] stat;
    logic urg_pend, rt_pend, rt_ok, want, launch, rel_open, rt_used, rt_take;

    irq_stat_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .ena_i  (ena_i),
        .rd_i   (rd_i),
        .stat_o (stat)
    );

    assign urg_pend = |(stat & URGENT_MASK);
    assign rt_pend  = |(stat & ROUTINE_MASK);
    assign rt_ok    = rt_pend && (!normal_i || !rt_used);
    assign want     = urg_pend || rt_ok;
    assign rt_take  = launch && normal_i && rt_ok;

    irq_rate_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .wd_tick_i (wd_tick_i),
        .take_i    (rt_take),
        .used_o    (rt_used)
    );

    irq_seq #(.REL_CYC(REL_CYC)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .want_i   (want),
        .rd_i     (rd_i),
        .irq_n_o  (irq_n_o),
        .launch_o (launch),
        .open_o   (rel_open)
    );

    assign rd_data_o = stat;
endmodule

// File: rtl/irq_throttle_chk.sv
module irq_throttle_chk
    import irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [STAT_W-1:0] evt_i,
    input logic [STAT_W-1:0] ena_i,
    input logic              rd_i,
    input logic [STAT_W-1:0] rd_data_o,
    input logic              wd_tick_i,
    input logic              normal_i,
    input logic              irq_n_o,
    input logic              rel_open,
    input logic              rt_used
);
    AST_READ_KEEPS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> rd_data_o == ($past(evt_i & ena_i) & VALID_MASK)); // R5

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o & ~VALID_MASK) == '0); // R3

    AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> irq_n_o); // R9

    AST_URGENT_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rd_data_o & URGENT_MASK) && !rd_i && rel_open) |=> !irq_n_o); // R6

    AST_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n_o && !rd_i) |=> !irq_n_o); // R10

    AST_ROUTINE_THROTTLED: assert property (@(posedge clk) disable iff (!rst_n)
        (normal_i && rt_used && !wd_tick_i && irq_n_o &&
         ((rd_data_o & URGENT_MASK) == '0)) |=> irq_n_o); // R8
endmodule

bind irq_throttle_ctrl irq_throttle_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .ena_i     (ena_i),
    .rd_i      (rd_i),
    .rd_data_o (rd_data_o),
    .wd_tick_i (wd_tick_i),
    .normal_i  (normal_i),
    .irq_n_o   (irq_n_o),
    .rel_open  (rel_open),
    .rt_used   (rt_used)
);

// File: tb/sim_irq_throttle_ctrl.sv
`timescale 1ns/1ps
module sim_irq_throttle_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] evt_i = '0;
    logic [11:0] ena_i = '0;
    logic        rd_i = 1'b0;
    logic [11:0] rd_data_o;
    logic        wd_tick_i = 1'b0;
    logic        normal_i = 1'b0;
    logic        irq_n_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct { logic [11:0] val; string tag; } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    irq_throttle_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .ena_i(ena_i), .rd_i(rd_i),
        .rd_data_o(rd_data_o), .wd_tick_i(wd_tick_i), .normal_i(normal_i),
        .irq_n_o(irq_n_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic [11:0] act, input logic [11:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic [11:0] v);
        evt_i = v;
        step();
        evt_i = '0;
    endtask

    // driver: queue the expected read value, then strobe the read
    task automatic read_expect(input logic [11:0] v, input string tag,
                               input logic [11:0] same_cycle_evt = '0);
        exp_t e;
        e.val = v;
        e.tag = tag;
        exp_q.push_back(e);
        rd_i  = 1'b1;
        evt_i = same_cycle_evt;
        step();
        rd_i  = 1'b0;
        evt_i = '0;
    endtask

    // monitor: compare read data while the strobe is high
    always @(negedge clk) begin
        if (rd_i && rst_n) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R4 unexpected read actual=%h expected=none", rd_data_o);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rd_data_o, e.val, e.tag);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check(rd_data_o, 12'h000, "R1 status after reset");
        check({11'd0, irq_n_o}, 12'h001, "R1 line after reset");

        ena_i = 12'hFFF;
        normal_i = 1'b1;

        // urgent supply fault (bit 7 -> 0x080? use bit 8 first)
        pulse(12'h100);
        check(rd_data_o, 12'h100, "R2 enabled bit latches");
        check({11'd0, irq_n_o}, 12'h001, "R6 line high in latch cycle");
        step();
        check({11'd0, irq_n_o}, 12'h000, "R6 urgent pulls line low");
        repeat (3) step();
        check({11'd0, irq_n_o}, 12'h000, "R10 line stays low until read");
        read_expect(12'h100, "R4 read returns status");
        check(rd_data_o, 12'h000, "R4 read empties status");
        check({11'd0, irq_n_o}, 12'h001, "R9 line released after read");
        repeat (5) step();

        // pulse in the read cycle is kept, then release window counts out
        read_expect(12'h000, "R4 read of empty word", 12'h080);
        check(rd_data_o, 12'h080, "R5 same-cycle pulse kept");
        for (int i = 0; i < 3; i++) begin
            check({11'd0, irq_n_o}, 12'h001, "R9 line high during release");
            step();
        end
        check({11'd0, irq_n_o}, 12'h001, "R9 line high in last release cycle");
        step();
        check({11'd0, irq_n_o}, 12'h000, "R9 line low after release");
        read_expect(12'h080, "R5 read of kept pulse");
        repeat (5) step();

        // disabled source and reserved inputs
        ena_i = 12'hBFF;
        pulse(12'h400);
        check(rd_data_o, 12'h000, "R2 disabled bit does not latch");
        repeat (2) step();
        check({11'd0, irq_n_o}, 12'h001, "R2 disabled bit leaves line high");
        ena_i = 12'hFFF;
        pulse(12'h222);
        check(rd_data_o, 12'h000, "R3 reserved bits read zero");

        // routine cause outside Normal mode acts at once
        normal_i = 1'b0;
        pulse(12'h010);
        step();
        check({11'd0, irq_n_o}, 12'h000, "R7 routine fires outside Normal");
        read_expect(12'h010, "R7 read routine bit");
        repeat (5) step();

        // Normal mode: first routine fires, second waits for the tick
        normal_i = 1'b1;
        pulse(12'h040);
        step();
        check({11'd0, irq_n_o}, 12'h000, "R8 first routine in period fires");
        read_expect(12'h040, "R8 read first routine");
        repeat (5) step();
        pulse(12'h008);
        check(rd_data_o, 12'h008, "R8 throttled cause still recorded");
        repeat (6) step();
        check({11'd0, irq_n_o}, 12'h001, "R8 second routine held back");
        wd_tick_i = 1'b1;
        step();
        wd_tick_i = 1'b0;
        check({11'd0, irq_n_o}, 12'h001, "R11 line high in tick cycle");
        step();
        check({11'd0, irq_n_o}, 12'h000, "R11 tick re-arms routine cause");
        read_expect(12'h008, "R11 read held cause");
        repeat (5) step();

        // urgent still fires while routine signalling is spent
        pulse(12'h801);
        step();
        check({11'd0, irq_n_o}, 12'h000, "R6 urgent fires while throttled");
        read_expect(12'h801, "R2 read mixed bits");
        check(rd_data_o, 12'h000, "R4 empty after mixed read");
        repeat (2) step();

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R4 reads pending actual=%0d expected=0", exp_q.size());
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule